// File: doc/BRIEF.md
# Bit-Serial Column-Counting Multiplier

This block multiplies two unsigned N-bit operands that arrive one bit of each per clock, least significant bit first. Whenever a new pair of bits arrives, the block forms every partial-product bit whose larger operand index equals the index of that pair. Each bit is made by a single AND gate and registered. The registered bits do not pass through full adders. They go to a small ones counter per partial-product column. So the whole partial-product matrix has been seen after exactly N accepted bit pairs. Each column of up to N bits is then held as a counter value of $clog2(N+1) bits.

Once the last bit pair has been counted, the column counts are weighted by their column position. A chain of carry-save stages reduces them to a sum row and a carry row, and a final carry-propagate adder forms the 2N-bit product. A `start` strobe clears the operation. `in_valid` marks the cycles that carry operand bits. `done` rises when the product is ready, and both stay held until the next `start`.

Top module: `bsmul_colcount`

## Requirements
- R1: After reset, and in the cycle after any clock edge at which `start` is high, `done` is 0 and `product` is all zeros.
- R2: Operand bits are taken, LSB first, only at clock edges where `in_valid` is high and `start` is low, and only for the first N such edges after `start`. `in_valid` in the `start` cycle, and any `in_valid` after N bits, has no effect.
- R3: When `done` is high, `product` equals the unsigned product of the N-bit operands A and B, where bit k of A and B is the k-th accepted `a_bit` and `b_bit`.
- R4: `done` rises at the third clock edge after the edge that takes the N-th bit pair, and never before N bits have been taken.
- R5: While `start` stays low, `done` and `product` hold their values, whatever `in_valid`, `a_bit` and `b_bit` do.
- R6: Each column count grows by 0, 1 or 2 per cycle and never exceeds that column's height: column c, of weight 2^c, holds at most min(c+1, 2N-1-c) bits.
- R7: Cycles with `in_valid` low between accepted bit pairs leave the result unchanged. They only delay `done` by the same number of cycles.
- R8: A `start` while an operation is in progress discards it, and the new operation gives the correct product of its own bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Clears state and begins a new operation |
| in_valid | input | 1 | `a_bit`/`b_bit` carry an operand bit this cycle |
| a_bit | input | 1 | Serial bit of operand A, LSB first |
| b_bit | input | 1 | Serial bit of operand B, LSB first |
| product | output | 2N | Unsigned product, valid while `done` is high |
| done | output | 1 | Product ready, held until the next `start` |

## Verification
The assertions assume that operands reach the block only through `in_valid` cycles that follow a `start`. They also assume that reset is applied before the first operation, so the registered operand bits and column counts start from zero. The stimulus always opens an operation with `start` and then feeds exactly N accepted bit pairs. The extra `in_valid` pulses it drives fall either in the `start` cycle itself or after the N-th bit, where the design must ignore them. Abandoned operations are always ended by a fresh `start`, so no property sees a partial matrix run on to completion.

// File: rtl/bsmul_colcount.sv
module bsmul_colcount #(
  parameter int N = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           in_valid,
  input  logic           a_bit,
  input  logic           b_bit,
  output logic [2*N-1:0] product,
  output logic           done
);
  localparam int PW   = 2 * N;
  localparam int NCOL = 2 * N - 1;
  localparam int CW   = $clog2(N + 1);
  localparam int IW   = $clog2(N + 1);

  logic [N-1:0]    a_q, b_q;
  logic [IW-1:0]   nbits;
  logic            take;
  logic [NCOL-1:0] pp_a_d, pp_b_d, pp_a_q, pp_b_q;
  logic            pp_vld;
  logic [CW-1:0]   cnt [NCOL];
  logic            cnt_done;
  logic [PW-1:0]   csa_s, csa_c, sum_q, car_q;
  logic            sum_vld;

  assign take = in_valid && !start && (nbits < IW'(N));

  // bit pair k meets every stored bit below k, plus the diagonal a_k*b_k
  assign pp_a_d = (NCOL'({N{a_bit}} & b_q) << nbits) | (NCOL'(a_bit & b_bit) << {nbits, 1'b0});
  assign pp_b_d = NCOL'({N{b_bit}} & a_q) << nbits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q    <= '0;
      b_q    <= '0;
      nbits  <= '0;
      pp_a_q <= '0;
      pp_b_q <= '0;
      pp_vld <= 1'b0;
    end else if (start) begin
      a_q    <= '0;
      b_q    <= '0;
      nbits  <= '0;
      pp_vld <= 1'b0;
    end else begin
      pp_vld <= take;
      if (take) begin
        a_q    <= a_q | (N'(a_bit) << nbits);
        b_q    <= b_q | (N'(b_bit) << nbits);
        nbits  <= nbits + 1'b1;
        pp_a_q <= pp_a_d;
        pp_b_q <= pp_b_d;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n || start) begin
      for (int c = 0; c < NCOL; c++) cnt[c] <= '0;
      cnt_done <= 1'b0;
    end else begin
      if (pp_vld)
        for (int c = 0; c < NCOL; c++)
          cnt[c] <= cnt[c] + CW'(pp_a_q[c]) + CW'(pp_b_q[c]);
      cnt_done <= pp_vld && (nbits == IW'(N));
    end
  end

  always_comb begin
    logic [PW-1:0] row, t;
    csa_s = '0;
    csa_c = '0;
    for (int c = 0; c < NCOL; c++) begin
      row   = PW'(cnt[c]) << c;
      t     = csa_s ^ csa_c ^ row;
      csa_c = ((csa_s & csa_c) | (csa_s & row) | (csa_c & row)) << 1;
      csa_s = t;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n || start) begin
      sum_q   <= '0;
      car_q   <= '0;
      sum_vld <= 1'b0;
      product <= '0;
      done    <= 1'b0;
    end else begin
      sum_vld <= cnt_done;
      if (cnt_done) begin
        sum_q <= csa_s;
        car_q <= csa_c;
      end
      if (sum_vld) begin
        product <= sum_q + car_q;
        done    <= 1'b1;
      end
    end
  end

  AST_START_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!done && product == '0 && nbits == '0)); // R1
  AST_NO_EXTRA_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (nbits == IW'(N) && !start) |=> nbits == IW'(N)); // R2
  AST_PRODUCT_OK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> product == PW'(a_q) * PW'(b_q)); // R3
  AST_DONE_AFTER_N: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> nbits == IW'(N)); // R4
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(product))); // R5

  for (genvar g = 0; g < NCOL; g++) begin : g_col_chk
    localparam int HC = (g < N) ? g + 1 : 2 * N - 1 - g;
    AST_COL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (pp_vld && !start) |=> ({1'b0, cnt[g]} >= {1'b0, $past(cnt[g])}) &&
                             ({1'b0, cnt[g]} - {1'b0, $past(cnt[g])} <= (CW+1)'(2))); // R6
    AST_COL_HEIGHT: assert property (@(posedge clk) disable iff (!rst_n)
      32'(cnt[g]) <= HC); // R6
  end
endmodule

// File: tb/bsmul_colcount_tb.sv
module bsmul_colcount_tb_top;
  localparam int N = 8;
  localparam int CLK_NS = 10;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, in_valid = 1'b0, a_bit = 1'b0, b_bit = 1'b0;
  logic [2*N-1:0] product;
  logic done;
  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  bsmul_colcount #(.N(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
    .a_bit(a_bit), .b_bit(b_bit), .product(product), .done(done));

  task automatic check(input bit ok, input string req, input logic [2*N-1:0] act, input logic [2*N-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // start cycle carries in_valid with ones bits, which must be ignored (R2)
  task automatic run_op(input logic [N-1:0] a, input logic [N-1:0] b, input bit gaps);
    logic [2*N-1:0] exp;
    int gap_n;
    exp = {{N{1'b0}}, a} * {{N{1'b0}}, b};
    gap_n = 0;
    @(negedge clk); start = 1'b1; in_valid = 1'b1; a_bit = 1'b1; b_bit = 1'b1;
    @(negedge clk); start = 1'b0;
    check(!done && product == '0, "R1 clear after start", {product[2*N-1:1], done}, '0);
    for (int k = 0; k < N; k++) begin
      if (gaps && (k % 3 == 1)) begin
        in_valid = 1'b0; a_bit = ~a[k]; b_bit = 1'b1; gap_n++;
        @(negedge clk);
      end
      in_valid = 1'b1; a_bit = a[k]; b_bit = b[k];
      @(negedge clk);
    end
    in_valid = 1'b0;
    check(!done, "R4 done low after last bit edge", 2*N'(done), '0);
    @(negedge clk);
    check(!done, "R4 done low one edge later", 2*N'(done), '0);
    @(negedge clk);
    check(!done, "R4 done low two edges later", 2*N'(done), '0);
    @(negedge clk);
    check(done, gaps ? "R7 done after gaps" : "R4 done at third edge", 2*N'(done), 1);
    check(product == exp, gaps ? "R7 R3 product with gaps" : "R3 R2 product", product, exp);
  endtask

  initial begin
    logic [N-1:0] corners [6];
    logic [2*N-1:0] held;
    corners[0] = '0; corners[1] = N'(1); corners[2] = '1;
    corners[3] = N'(1) << (N-1); corners[4] = {(N/2){2'b01}}; corners[5] = {(N/2){2'b10}};
    repeat (3) @(negedge clk);
    check(!done && product == '0, "R1 reset state", product, '0);
    rst_n = 1'b1;
    @(negedge clk);

    run_op('1, '1, 1'b0);
    check(product == ({{N{1'b0}}, {N{1'b1}}} * {{N{1'b0}}, {N{1'b1}}}), "R6 all-ones full columns", product,
          {{N{1'b0}}, {N{1'b1}}} * {{N{1'b0}}, {N{1'b1}}});

    for (int a = 0; a < (1 << N); a++)
      for (int j = 0; j < 6; j++) begin
        run_op(N'(a), corners[j], 1'b0);
        run_op(corners[j], N'(a), 1'b0);
      end

    for (int i = 0; i < 400; i++) run_op(N'($urandom), N'($urandom), 1'b1);

    // R5 and R2: bits after N have no effect on a held result
    run_op(N'(8'hb7), N'(8'h5d), 1'b0);
    held = product;
    for (int i = 0; i < 6; i++) begin
      in_valid = 1'b1; a_bit = 1'b1; b_bit = (i % 2 == 0);
      @(negedge clk);
      check(done && product == held, "R5 R2 hold under extra bits", product, held);
    end
    in_valid = 1'b0;

    // R8: abort a partial operation with a new start
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      for (int k = 0; k < 1 + (i % (N-1)); k++) begin
        in_valid = 1'b1; a_bit = 1'b1; b_bit = 1'b1;
        @(negedge clk);
      end
      in_valid = 1'b0;
      run_op(N'($urandom), N'(i * 13 + 5), 1'b0);
      check(done, "R8 restart completes", 2*N'(done), 1);
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_NS * 190000);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule